// File: doc/BRIEF.md
# Per-Channel Block Error Counter

This block watches one line channel and counts frames that arrived with transmission errors, so that a host can judge link quality. Once per frame a boundary strobe arrives. Between two strobes the block remembers whether any code violation was flagged. When the strobe arrives it decides whether the frame that just ended was errored. It then adds one to an 8-bit saturating counter. A host read strobe returns the current count and clears it.

A static mode input selects between two sides of the link. In network-termination mode (`lt_mode_i` = 0), only local code violations count. Each errored frame also raises an indicator bit, which is sent back upstream during the following frame. In line-termination mode (`lt_mode_i` = 1), the far-end indicator received with a frame counts as an error as well. A frame with both kinds of error still adds only one. Counting is allowed only while the link-state code shows an active state. In every other state the counter is held at zero.

All pins are plain control and status signals. The count is a level that the host samples in its read cycle. The block therefore has no streaming handshake and applies no back-pressure.

Top module: `blkerr_mon`

## Requirements
- R1: A frame is errored when `cv_i` was high in at least one cycle of that frame. The strobe cycle belongs to the ending frame. On the edge that ends an errored frame, `count_o` rises by one.
- R2: Several code violations within one frame add exactly one to the count.
- R3: In network-termination mode, `up_ind_o` is updated on the strobe edge. It takes the value 1 if the ending frame was errored and 0 otherwise. Between strobes it holds its value. In this mode `far_ind_i` has no effect.
- R4: In line-termination mode, `far_ind_i` high in the strobe cycle makes the frame errored. A frame with both a far-end and a near-end error adds one, not two. In this mode `up_ind_o` stays 0.
- R5: In the cycle where `rd_i` is high, `count_o` shows the current count. On the next edge the count becomes 0.
- R6: If a read and an errored frame boundary fall in the same cycle, the count becomes 1.
- R7: Link-state codes 4, 5 and 6 are active. Any other code forces the count to 0 on the next edge, and errors are not counted in that state.
- R8: The count saturates at 255. A further errored frame leaves it at 255.
- R9: During reset (`rst_ni` low), `count_o` is 0 and `up_ind_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lt_mode_i | input | 1 | 0 network-termination side, 1 line-termination side (static) |
| link_state_i | input | 3 | Link-state code; 4, 5 and 6 allow counting |
| frame_end_i | input | 1 | One-cycle strobe on the last cycle of a frame |
| cv_i | input | 1 | Code violation seen in this cycle |
| far_ind_i | input | 1 | Received far-end error indicator, valid with the strobe |
| rd_i | input | 1 | Host read: returns the count and clears it |
| count_o | output | 8 | Block error count |
| up_ind_o | output | 1 | Indicator to send upstream in the next frame |

## Verification
The assertions assume the following about the inputs:
- `lt_mode_i` is static outside reset, since the indicator checks compare strobe outcomes against it.
- `frame_end_i` is a single-cycle pulse.
- `far_ind_i` matters only in the strobe cycle.

The stimulus meets these assumptions in three ways:
- It changes the mode only while reset is held.
- It drives every frame as a run of at least two cycles that ends with exactly one strobe cycle.
- It raises the far-end bit only on that final cycle.

Link-state changes and reads are driven between frames or on a strobe cycle. This exercises the collision of a read with an errored frame.

// File: rtl/blkerr_pkg.sv
package blkerr_pkg;
  typedef struct packed {
    logic evt;
    logic near;
    logic far;
  } frame_res_t;
endpackage

// File: rtl/blkerr_cv_latch.sv
module blkerr_cv_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cv_i,
  input  logic frame_end_i,
  output logic frame_cv_o
);
  logic seen_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)          seen_q <= 1'b0;
    else if (frame_end_i) seen_q <= 1'b0;
    else if (cv_i)        seen_q <= 1'b1;
  end

  // violation in the strobe cycle still belongs to the ending frame
  assign frame_cv_o = seen_q | cv_i;

  // R2: a new frame starts clean after each strobe
  assert_latch_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> (cv_i || !frame_cv_o));
  // R1: once a violation is seen the frame stays marked until the strobe
  assert_latch_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cv_i && !frame_end_i) |=> frame_cv_o);
endmodule

// File: rtl/blkerr_detect.sv
module blkerr_detect
  import blkerr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lt_mode_i,
  input  logic       frame_end_i,
  input  logic       frame_cv_i,
  input  logic       far_ind_i,
  output frame_res_t res_o,
  output logic       up_ind_o
);
  logic up_q;

  always_comb begin
    res_o.near = frame_end_i & frame_cv_i;
    res_o.far  = frame_end_i & lt_mode_i & far_ind_i;
    res_o.evt  = res_o.near | res_o.far;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)          up_q <= 1'b0;
    else if (frame_end_i) up_q <= ~lt_mode_i & frame_cv_i;
  end

  assign up_ind_o = up_q;

  // R3: the indicator only moves at a frame boundary
  assert_up_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(up_ind_o));
  // R4: no upstream indicator on the line-termination side
  assert_lt_no_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && lt_mode_i) |=> !up_ind_o);
endmodule

// File: rtl/blkerr_sat_cnt.sv
module blkerr_sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             rd_i,
  input  logic             evt_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!active_i)                cnt_q <= '0;
    else if (rd_i)                     cnt_q <= evt_i ? CNT_ONE : '0;
    else if (evt_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o = cnt_q;

  assert_inc_one_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !rd_i && evt_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + CNT_ONE);
  assert_rd_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && rd_i && !evt_i) |=> cnt_o == '0);
  assert_rd_evt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && rd_i && evt_i) |=> cnt_o == CNT_ONE);
  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> cnt_o == '0);
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !rd_i && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !rd_i && !evt_i) |=> $stable(cnt_o));
endmodule

// File: rtl/blkerr_mon.sv
module blkerr_mon
  import blkerr_pkg::*;
#(
  parameter int                    CNT_W      = 8,
  parameter int                    LINK_W     = 3,
  parameter logic [2**LINK_W-1:0]  ACTIVE_SET = 8'b0111_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lt_mode_i,
  input  logic [LINK_W-1:0] link_state_i,
  input  logic              frame_end_i,
  input  logic              cv_i,
  input  logic              far_ind_i,
  input  logic              rd_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              up_ind_o
);
  logic       frame_cv;
  logic       active;
  frame_res_t res;

  assign active = ACTIVE_SET[link_state_i];

  blkerr_cv_latch u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cv_i        (cv_i),
    .frame_end_i (frame_end_i),
    .frame_cv_o  (frame_cv)
  );

  blkerr_detect u_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lt_mode_i   (lt_mode_i),
    .frame_end_i (frame_end_i),
    .frame_cv_i  (frame_cv),
    .far_ind_i   (far_ind_i),
    .res_o       (res),
    .up_ind_o    (up_ind_o)
  );

  blkerr_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .rd_i     (rd_i),
    .evt_i    (res.evt),
    .cnt_o    (count_o)
  );

  // R4: a frame with both error sources still adds one
  assert_both_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !rd_i && res.near && res.far && count_o != {CNT_W{1'b1}})
      |=> count_o == $past(count_o) + CNT_W'(1));
endmodule

// File: tb/test_blkerr_mon.sv
module test_blkerr_mon;
  typedef struct {
    int    cnt;
    bit    up;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lt_mode = 1'b0;
  logic [2:0] link = 3'd5;
  logic       fe = 1'b0, cv = 1'b0, far = 1'b0, rd = 1'b0;
  logic [7:0] count;
  logic       up_ind;

  exp_t q[$];
  int   checks = 0, errors = 0;
  int   m_cnt = 0;
  bit   m_up = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  blkerr_mon i_blkerr_mon (
    .clk_i(clk), .rst_ni(rst_n), .lt_mode_i(lt_mode), .link_state_i(link),
    .frame_end_i(fe), .cv_i(cv), .far_ind_i(far), .rd_i(rd),
    .count_o(count), .up_ind_o(up_ind)
  );

  function automatic bit is_active(input logic [2:0] c);
    return (c == 3'd4) || (c == 3'd5) || (c == 3'd6);
  endfunction

  function automatic void apply(input bit evt, input bit r);
    if (!is_active(link))  m_cnt = 0;
    else if (r)            m_cnt = evt ? 1 : 0;
    else if (evt && m_cnt < 255) m_cnt = m_cnt + 1;
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.cnt = m_cnt; e.up = m_up; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (count !== 8'(e.cnt) || up_ind !== e.up) begin
          errors++;
          $display("FAIL %s: count=%0d up=%0b expected count=%0d up=%0b",
                   e.tag, count, up_ind, e.cnt, e.up);
        end
      end
    end
  end

  task automatic do_reset(input bit lt);
    @(negedge clk);
    rst_n = 1'b0; lt_mode = lt;
    repeat (2) @(negedge clk);
    m_cnt = 0; m_up = 1'b0;
    push("R9 reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // frame of len cycles; cv at cv_at (and cv_at+1 if twice); far and rd on strobe
  task automatic do_frame(input int len, input int cv_at, input bit twice,
                          input bit far_b, input bit rd_b, input string tag);
    bit errd = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      fe  = (i == len - 1);
      cv  = (i == cv_at) || (twice && i == cv_at + 1);
      far = (i == len - 1) ? far_b : 1'b0;
      rd  = (i == len - 1) ? rd_b : 1'b0;
      if (cv) errd = 1'b1;
      if (rd) push({tag, " read value"});
    end
    @(negedge clk);
    fe = 1'b0; cv = 1'b0; far = 1'b0; rd = 1'b0;
    apply(errd || (lt_mode && far_b), rd_b);
    m_up = !lt_mode && errd;
    push(tag);
  endtask

  task automatic host_read(input string tag);
    @(negedge clk);
    rd = 1'b1;
    push({tag, " read value"});
    @(negedge clk);
    rd = 1'b0;
    apply(1'b0, 1'b1);
    push(tag);
  endtask

  task automatic set_link(input logic [2:0] c, input string tag);
    @(negedge clk);
    link = c;
    @(negedge clk);
    apply(1'b0, 1'b0);
    push(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push(tag);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // network-termination side
    do_reset(1'b0);
    do_frame(4, 1, 0, 0, 0, "R1 single cv");
    do_frame(4, 0, 1, 0, 0, "R2 two cv one frame");
    do_frame(3, -1, 0, 1, 0, "R3 far ignored in NT");
    do_frame(2, 1, 0, 0, 0, "R1 cv on strobe cycle");
    idle(3, "R3 indicator held between strobes");
    host_read("R5 read clears");
    do_frame(3, 0, 0, 0, 1, "R6 read with error");
    set_link(3'd3, "R7 inactive clears");
    do_frame(3, 1, 0, 0, 0, "R7 error while inactive");
    set_link(3'd7, "R7 code 7 inactive");
    set_link(3'd4, "R7 code 4 active");
    do_frame(3, 1, 0, 0, 0, "R7 counts when active");
    // line-termination side
    link = 3'd6;
    do_reset(1'b1);
    do_frame(3, -1, 0, 1, 0, "R4 far only");
    do_frame(3, 0, 0, 1, 0, "R4 both count once");
    do_frame(3, -1, 0, 0, 0, "R4 clean frame");
    do_frame(3, 1, 0, 0, 0, "R4 near only");
    host_read("R5 read in LT");
    for (int k = 0; k < 258; k++) do_frame(2, 0, 0, 0, 0, "R8 fill");
    do_frame(2, 0, 0, 1, 0, "R8 saturated");
    do_frame(2, 1, 0, 0, 1, "R6 read at max with error");
    idle(2, "R9 idle");
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule